// File: doc/BRIEF.md
# Work-Group Vector Add Engine

This engine adds two vectors of 32-bit signed integers element by element. One launch covers one fixed-size work group of 128 elements. Before a launch, the surrounding logic presents three byte base addresses (input A, input B, output C), an x work-group index and an x global offset. A one-cycle start pulse while the engine is idle latches these values.

For each element, the engine reads A through a single memory read port, then reads B through the same port. It waits for both returns, then presents the sum on a memory write port. Writes go out in increasing element order. After the last write is accepted, the engine returns to idle, raises a sticky done flag and pulses ready for one cycle.

Vectors longer than one group take repeated launches with successive work-group indices. The y and z work-group dimensions are not part of this one-dimensional engine and have no inputs.

Top module: `wg_vadd_engine`

## Requirements
- R1: Out of reset, and whenever the engine is idle, `idle_o`=1, `rd_req_o`=0 and `wr_valid_o`=0; right after reset `done_o`=0 and `ready_o`=0.
- R2: Each accepted launch produces exactly `WG_SIZE` (default 128) write handshakes, one per local index 0..WG_SIZE-1, in increasing index order, so consecutive write addresses differ by 4.
- R3: The data written for an element is the two's-complement sum, modulo 2^32, of the A and B words read for that element.
- R4: The global index of local element i is `group_x_i`*WG_SIZE + `offset_x_i` + i. Its byte address in each vector is base + 4*index, and every step is taken modulo 2^32.
- R5: For each element, the engine issues exactly one read of A, then one read of B. It issues the write only after both read data words have returned (`rd_valid_i` strobes, in request order). Read requests and write requests are never asserted together.
- R6: A start pulse seen while `idle_o`=1 is accepted. `idle_o` drops in the next cycle and rises again in the cycle after the last write handshake.
- R7: A start pulse while the engine is busy is ignored: the running launch finishes unchanged, and no extra launch follows.
- R8: `done_o` rises in the same cycle that `idle_o` rises after a launch. It then holds until the next accepted start clears it, in the cycle after that start.
- R9: `ready_o` is high for exactly one cycle, namely the cycle in which `done_o` rises.
- R10: While `wr_valid_o`=1 and `wr_ready_i`=0, `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold their values.
- R11: Base addresses, work-group index and offset are sampled only when a start is accepted. Changing them during a launch does not affect that launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch request pulse |
| base_a_i | input | 32 | Byte base address of input A |
| base_b_i | input | 32 | Byte base address of input B |
| base_c_i | input | 32 | Byte base address of output C |
| group_x_i | input | 32 | x work-group index |
| offset_x_i | input | 32 | x global element offset |
| idle_o | output | 1 | Engine waiting for a launch |
| done_o | output | 1 | Last launch completed (sticky) |
| ready_o | output | 1 | One-cycle pulse: a new launch can be taken |
| rd_req_o | output | 1 | Read request, always accepted by memory |
| rd_addr_o | output | 32 | Read byte address |
| rd_valid_i | input | 1 | Read data return strobe |
| rd_data_i | input | 32 | Read data |
| wr_valid_o | output | 1 | Write request |
| wr_addr_o | output | 32 | Write byte address |
| wr_data_o | output | 32 | Write data |
| wr_ready_i | input | 1 | Memory accepts the write |

## Verification
The addition is tried with three data patterns:
- Hashed per-address words expose a swapped or stale operand.
- Saturated positive words expose a wrong wrap on overflow.
- Alternating small positive and negative words expose sign handling.

Launches run with zero and non-zero read latency, and with and without write back-pressure. These separate the waiting logic from the handshake hold. Launches with a non-zero group index and offset, and with bases and group indices that cross 2^32, check the index arithmetic. A busy-time start combined with changed base registers shows that neither leaks into the running group.

// File: rtl/vadd_pkg.sv
package vadd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_A,
    ST_WAIT_A,
    ST_REQ_B,
    ST_WAIT_B,
    ST_WRITE
  } vadd_state_e;
endpackage

// File: rtl/vadd_seq.sv
module vadd_seq
  import vadd_pkg::*;
#(
  parameter int WG_SIZE = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        rd_valid_i,
  input  logic        wr_ready_i,
  output vadd_state_e state_o,
  output logic        launch_o,
  output logic        advance_o,
  output logic        cap_a_o,
  output logic        cap_b_o,
  output logic        done_o,
  output logic        ready_o
);
  localparam int IDX_W = (WG_SIZE > 1) ? $clog2(WG_SIZE) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WG_SIZE - 1);

  vadd_state_e state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic done_q, ready_q;
  logic last_elem;

  assign last_elem = (idx_q == LAST_IDX);
  assign launch_o  = (state_q == ST_IDLE) && start_i;
  assign advance_o = (state_q == ST_WRITE) && wr_ready_i;
  assign cap_a_o   = (state_q == ST_WAIT_A) && rd_valid_i;
  assign cap_b_o   = (state_q == ST_WAIT_B) && rd_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_REQ_A;
      ST_REQ_A:  state_d = ST_WAIT_A;
      ST_WAIT_A: if (rd_valid_i) state_d = ST_REQ_B;
      ST_REQ_B:  state_d = ST_WAIT_B;
      ST_WAIT_B: if (rd_valid_i) state_d = ST_WRITE;
      ST_WRITE:  if (wr_ready_i) state_d = last_elem ? ST_IDLE : ST_REQ_A;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= advance_o && last_elem;
      if (launch_o) begin
        idx_q  <= '0;
        done_q <= 1'b0;
      end else if (advance_o) begin
        idx_q <= idx_q + 1'b1;
        if (last_elem) done_q <= 1'b1;
      end
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/vadd_addr.sv
module vadd_addr #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int WG_SIZE = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_i,
  input  logic              advance_i,
  input  logic [ADDR_W-1:0] base_a_i,
  input  logic [ADDR_W-1:0] base_b_i,
  input  logic [ADDR_W-1:0] base_c_i,
  input  logic [ADDR_W-1:0] group_x_i,
  input  logic [ADDR_W-1:0] offset_x_i,
  output logic [ADDR_W-1:0] addr_a_o,
  output logic [ADDR_W-1:0] addr_b_o,
  output logic [ADDR_W-1:0] addr_c_o
);
  localparam int BYTE_SH = $clog2(DATA_W / 8);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);
  localparam bit WG_POW2 = (WG_SIZE & (WG_SIZE - 1)) == 0;

  logic [ADDR_W-1:0] group_first;
  logic [ADDR_W-1:0] first_elem;
  logic [ADDR_W-1:0] base_a_q, base_b_q, base_c_q, off_q;

  generate
    if (WG_POW2) begin : g_shift
      assign group_first = group_x_i << $clog2(WG_SIZE);
    end else begin : g_mult
      assign group_first = group_x_i * ADDR_W'(WG_SIZE);
    end
  endgenerate

  assign first_elem = group_first + offset_x_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_a_q <= '0;
      base_b_q <= '0;
      base_c_q <= '0;
      off_q    <= '0;
    end else if (launch_i) begin
      base_a_q <= base_a_i;
      base_b_q <= base_b_i;
      base_c_q <= base_c_i;
      off_q    <= first_elem << BYTE_SH;
    end else if (advance_i) begin
      off_q <= off_q + STEP;
    end
  end

  assign addr_a_o = base_a_q + off_q;
  assign addr_b_o = base_b_q + off_q;
  assign addr_c_o = base_c_q + off_q;
endmodule

// File: rtl/vadd_datapath.sv
module vadd_datapath #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] sum_o
);
  logic [DATA_W-1:0] a_q, sum_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      sum_q <= '0;
    end else begin
      if (cap_a_i) a_q <= rd_data_i;
      if (cap_b_i) sum_q <= a_q + rd_data_i;
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/wg_vadd_engine.sv
module wg_vadd_engine
  import vadd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int WG_SIZE = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_a_i,
  input  logic [ADDR_W-1:0] base_b_i,
  input  logic [ADDR_W-1:0] base_c_i,
  input  logic [ADDR_W-1:0] group_x_i,
  input  logic [ADDR_W-1:0] offset_x_i,
  output logic              idle_o,
  output logic              done_o,
  output logic              ready_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i
);
  vadd_state_e state;
  logic launch, advance, cap_a, cap_b;
  logic [ADDR_W-1:0] addr_a, addr_b, addr_c;

  vadd_seq #(.WG_SIZE(WG_SIZE)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .rd_valid_i(rd_valid_i),
    .wr_ready_i(wr_ready_i), .state_o(state), .launch_o(launch),
    .advance_o(advance), .cap_a_o(cap_a), .cap_b_o(cap_b),
    .done_o(done_o), .ready_o(ready_o)
  );

  vadd_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WG_SIZE(WG_SIZE)) u_addr (
    .clk(clk), .rst(rst), .launch_i(launch), .advance_i(advance),
    .base_a_i(base_a_i), .base_b_i(base_b_i), .base_c_i(base_c_i),
    .group_x_i(group_x_i), .offset_x_i(offset_x_i),
    .addr_a_o(addr_a), .addr_b_o(addr_b), .addr_c_o(addr_c)
  );

  vadd_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .cap_a_i(cap_a), .cap_b_i(cap_b),
    .rd_data_i(rd_data_i), .sum_o(wr_data_o)
  );

  assign idle_o     = (state == ST_IDLE);
  assign rd_req_o   = (state == ST_REQ_A) || (state == ST_REQ_B);
  assign rd_addr_o  = (state == ST_REQ_B) ? addr_b : addr_a;
  assign wr_valid_o = (state == ST_WRITE);
  assign wr_addr_o  = addr_c;
endmodule

// File: rtl/vadd_engine_checker.sv
module vadd_engine_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              idle_o,
  input logic              done_o,
  input logic              ready_o,
  input logic              rd_req_o,
  input logic              wr_valid_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              wr_ready_i
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic [ADDR_W-1:0] last_addr;
  logic              seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= 1'b0;
      last_addr <= '0;
    end else if (idle_o && start_i) begin
      seen <= 1'b0;
    end else if (wr_valid_o && wr_ready_i) begin
      seen      <= 1'b1;
      last_addr <= wr_addr_o;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    idle_o |-> (!rd_req_o && !wr_valid_o));
  a_r2_wr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && wr_ready_i && seen) |-> (wr_addr_o == last_addr + STEP));
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(rd_req_o && wr_valid_o));
  a_r6_idle_falls: assert property (@(posedge clk) disable iff (rst)
    (idle_o && start_i) |=> !idle_o);
  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> idle_o);
  a_r9_ready_with_done: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (done_o && $rose(done_o)));
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);
  a_r10_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));
endmodule

bind wg_vadd_engine vadd_engine_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .idle_o(idle_o), .done_o(done_o),
  .ready_o(ready_o), .rd_req_o(rd_req_o), .wr_valid_o(wr_valid_o),
  .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ready_i(wr_ready_i)
);

// File: tb/wg_vadd_engine_bench.sv
`timescale 1ns/1ps
module wg_vadd_engine_bench;
  localparam int WG = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [31:0] base_a_i = '0, base_b_i = '0, base_c_i = '0;
  logic [31:0] group_x_i = '0, offset_x_i = '0;
  logic idle_o, done_o, ready_o, rd_req_o, wr_valid_o;
  logic [31:0] rd_addr_o, wr_addr_o, wr_data_o;
  logic rd_valid_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic wr_ready_i = 1'b1;

  always #4 clk = ~clk;

  wg_vadd_engine u_wg_vadd_engine (
    .clk(clk), .rst(rst), .start_i(start_i), .base_a_i(base_a_i),
    .base_b_i(base_b_i), .base_c_i(base_c_i), .group_x_i(group_x_i),
    .offset_x_i(offset_x_i), .idle_o(idle_o), .done_o(done_o),
    .ready_o(ready_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .wr_valid_o(wr_valid_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ready_i(wr_ready_i)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int pat = 0, lat = 0;
  bit stall = 0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    case (pat)
      0:       return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
      1:       return 32'h7FFFFFFF;
      default: return a[3] ? 32'hFFFFFFFB : 32'h00000003;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: one outstanding read, fixed latency, write ready pattern
  initial begin
    bit have = 0;
    int cnt = 0;
    int tick = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      if (!rst && rd_req_o && !have) begin
        have = 1; cnt = lat; paddr = rd_addr_o;
      end
      @(posedge clk);
      #1;
      tick++;
      rd_valid_i = 1'b0;
      if (have) begin
        if (cnt == 0) begin
          rd_valid_i = 1'b1; rd_data_i = memf(paddr); have = 0;
        end else cnt--;
      end
      wr_ready_i = stall ? (tick % 3 == 0) : 1'b1;
    end
  end

  // reference model, compared on every clock
  logic [31:0] exp_rd_q[$], exp_wa_q[$], exp_wd_q[$];
  bit exp_idle = 1, exp_done = 0, exp_ready = 0;
  int rd_ret = 0, wr_cnt = 0;
  bit hold = 0;
  logic [31:0] hold_addr, hold_data;

  always @(negedge clk) begin
    if (!rst) begin
      bit fin;
      fin = 0;
      chk(32'(idle_o), 32'(exp_idle), "R6 idle_o");
      chk(32'(done_o), 32'(exp_done), "R8 done_o");
      chk(32'(ready_o), 32'(exp_ready), "R9 ready_o");
      if (exp_idle) begin
        chk(32'(rd_req_o), 0, "R1 rd_req_o while idle");
        chk(32'(wr_valid_o), 0, "R1 wr_valid_o while idle");
      end
      if (hold) begin
        chk(32'(wr_valid_o), 1, "R10 wr_valid_o held");
        chk(wr_addr_o, hold_addr, "R10 wr_addr_o held");
        chk(wr_data_o, hold_data, "R10 wr_data_o held");
      end
      chk(32'(rd_req_o && wr_valid_o), 0, "R5 read and write together");
      if (rd_valid_i) rd_ret++;
      if (rd_req_o) begin
        if (exp_rd_q.size() == 0) chk(32'(rd_req_o), 0, "R5 unexpected read");
        else chk(rd_addr_o, exp_rd_q.pop_front(), "R4 read address");
      end
      if (wr_valid_o && wr_ready_i) begin
        chk(rd_ret, 2 * (wr_cnt + 1), "R5 reads returned before write");
        wr_cnt++;
        if (exp_wa_q.size() == 0) chk(32'(wr_valid_o), 0, "R2 extra write");
        else begin
          chk(wr_addr_o, exp_wa_q.pop_front(), "R2 R4 write address");
          chk(wr_data_o, exp_wd_q.pop_front(), "R3 write data");
          if (exp_wa_q.size() == 0) fin = 1;
        end
      end
      hold = wr_valid_o && !wr_ready_i;
      hold_addr = wr_addr_o;
      hold_data = wr_data_o;
      exp_ready = fin;
      if (exp_idle && start_i) begin
        exp_idle = 0; exp_done = 0; rd_ret = 0; wr_cnt = 0;
        for (int i = 0; i < WG; i++) begin
          logic [31:0] g;
          g = group_x_i * WG + offset_x_i + i;
          exp_rd_q.push_back(base_a_i + 4 * g);
          exp_rd_q.push_back(base_b_i + 4 * g);
          exp_wa_q.push_back(base_c_i + 4 * g);
          exp_wd_q.push_back(memf(base_a_i + 4 * g) + memf(base_b_i + 4 * g));
        end
      end else if (fin) begin
        exp_idle = 1; exp_done = 1;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

  task automatic run(input logic [31:0] ba, input logic [31:0] bb, input logic [31:0] bc,
                     input logic [31:0] gx, input logic [31:0] ox, input int busy_poke);
    @(posedge clk); #1;
    base_a_i = ba; base_b_i = bb; base_c_i = bc; group_x_i = gx; offset_x_i = ox;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (busy_poke > 0) begin
      // R7 R11: busy-time start with changed registers is ignored
      repeat (busy_poke) @(posedge clk);
      #1;
      base_a_i = 32'hDEAD0000; base_b_i = 32'hBEEF0000; base_c_i = 32'h0;
      group_x_i = 32'd9; offset_x_i = 32'd1; start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
    end
    while (!exp_idle) @(posedge clk);
    #1;
    chk(exp_wa_q.size(), 0, "R2 all writes seen");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    chk(32'(idle_o), 1, "R1 reset idle_o");
    chk(32'(done_o), 0, "R1 reset done_o");
    chk(32'(ready_o), 0, "R1 reset ready_o");
    chk(32'(rd_req_o | wr_valid_o), 0, "R1 reset requests");

    pat = 0; lat = 0; stall = 0;
    run(32'h0000_1000, 32'h0000_2000, 32'h0000_3000, 0, 0, 0);
    pat = 0; lat = 2; stall = 1;
    run(32'h0001_0000, 32'h0002_0000, 32'h0003_0000, 3, 5, 0);
    pat = 1; lat = 1; stall = 0;
    run(32'h0010_0000, 32'h0020_0000, 32'h0030_0000, 1, 0, 0);
    pat = 2; lat = 0; stall = 1;
    run(32'h0040_0000, 32'h0050_0004, 32'hFFFF_FF00, 0, 0, 0);
    pat = 0; lat = 3; stall = 0;
    run(32'hFFFF_FFF0, 32'h0000_0100, 32'h0000_8000, 32'h0200_0000, 32'd7, 0);
    pat = 0; lat = 1; stall = 1;
    run(32'h0100_0000, 32'h0200_0000, 32'h0300_0000, 2, 0, 40);
    pat = 2; lat = 0; stall = 0;
    run(32'h0400_0000, 32'h0500_0000, 32'h0600_0000, 4, 3, 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(32'(done_o), 1, "R8 done held while idle");
    summary();
  end
endmodule